// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character per handshake into an asynchronous serial frame on a single line. A frame is a low start bit, five to nine data bits sent least significant first, an optional even or odd parity bit, and one or two high stop bits. The line sits high between frames. The pacing comes from an external baud tick that is one clock wide, and every bit on the line lasts from one tick to the next.

The data length, the parity mode and the stop count are plain inputs. They are sampled when a character is accepted and are held for that whole frame. This gives thirty usable formats, and a change to the inputs never disturbs a frame already on the line. A character offered while a frame is running is taken on the tick that ends the last stop bit, so the next start bit follows with no idle time.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txLine` is 1 and `busy` is 0.
- R2: `inReady` is 1 only in a cycle where `baudTick` is 1 and the transmitter is idle or sending its last stop bit. A character is accepted on a clock edge where `inValid` and `inReady` are both 1. The start bit (0) appears on `txLine` in the cycle after that edge.
- R3: Data bits follow the start bit, bit 0 first. Their count is `cfgDataLen`, where a value below 5 counts as 5 and a value above 9 counts as 9.
- R4: `cfgParity` uses 0 = none, 1 = even, 2 = odd and 3 = none. With even or odd parity, one parity bit follows the last data bit. It makes the number of ones across the sent data bits plus the parity bit even (even mode) or odd (odd mode).
- R5: One stop bit (1) is sent when `cfgTwoStop` is 0, and two stop bits when it is 1.
- R6: A character accepted on the tick that ends the last stop bit starts its start bit immediately, with no idle bit in between.
- R7: Format inputs are captured at acceptance. Changing them while a frame is on the line has no effect on that frame.
- R8: `txLine` changes only in the cycle after a clock edge where `baudTick` was 1, so each bit lasts exactly one tick interval.
- R9: `busy` is 1 from the cycle after acceptance until the tick that ends the last stop bit, unless a new character is accepted on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse marking each bit boundary |
| inData | input | 9 | Character to send, bit 0 sent first |
| inValid | input | 1 | A character is offered |
| inReady | output | 1 | Character is taken at this edge if valid |
| cfgDataLen | input | 4 | Data bit count, clamped to 5..9 |
| cfgParity | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| txLine | output | 1 | Serial output, high when idle |
| busy | output | 1 | A frame is on the line |

## Verification
A character is taken at a tick edge, and its start bit is on the line one clock later. Each later bit of the frame appears one clock after each following tick edge. The monitor therefore remembers whether the tick was high at each rising edge, and samples `txLine` and `busy` at the next falling edge, popping one expected bit per tick. At falling edges with no preceding tick, it requires the line to be unchanged. The driver offers the next character as soon as the previous one is accepted and changes the format inputs at the same time, so back-to-back timing and format capture are both checked against the queued bit order.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic load;        // capture character, drive start bit
    logic sendData;    // drive next data bit and shift
    logic sendParity;  // drive stored parity bit
    logic sendHigh;    // drive stop level
  } txStrobe_t;

  localparam logic [1:0] PAR_NONE = 2'd0;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  function automatic int clampLen(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/sftx_ctrl.sv
module sftx_ctrl
  import sftx_pkg::*;
#(
  parameter int MIN_DATA = 5,
  parameter int MAX_DATA = 9,
  parameter int LEN_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             inValid,
  input  logic [LEN_W-1:0] cfgDataLen,
  input  logic [1:0]       cfgParity,
  input  logic             cfgTwoStop,
  output logic             inReady,
  output logic             busy,
  output txStrobe_t        strobe
);

  txState_t         state;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] bitCnt;
  logic             parEnQ;
  logic             twoStopQ;
  logic             stopIdx;
  logic             lastData;
  logic             lastStop;
  logic             accept;
  logic [LEN_W-1:0] effLen;

  always_comb begin
    effLen   = LEN_W'(clampLen(int'(cfgDataLen), MIN_DATA, MAX_DATA));
    lastData = (bitCnt == lenQ - LEN_W'(1));
    lastStop = (state == ST_STOP) && (!twoStopQ || stopIdx);
    inReady  = baudTick && ((state == ST_IDLE) || lastStop);
    accept   = inValid && inReady;
    busy     = (state != ST_IDLE);
  end

  always_comb begin
    strobe            = '0;
    strobe.load       = accept;
    strobe.sendData   = baudTick && ((state == ST_START) ||
                        ((state == ST_DATA) && !lastData));
    strobe.sendParity = baudTick && (state == ST_DATA) && lastData && parEnQ;
    strobe.sendHigh   = baudTick && (((state == ST_DATA) && lastData && !parEnQ) ||
                        (state == ST_PARITY));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lenQ     <= LEN_W'(MIN_DATA);
      bitCnt   <= '0;
      parEnQ   <= 1'b0;
      twoStopQ <= 1'b0;
      stopIdx  <= 1'b0;
    end else if (accept) begin
      state    <= ST_START;
      lenQ     <= effLen;
      parEnQ   <= (cfgParity == PAR_EVEN) || (cfgParity == PAR_ODD);
      twoStopQ <= cfgTwoStop;
      bitCnt   <= '0;
      stopIdx  <= 1'b0;
    end else if (baudTick) begin
      unique case (state)
        ST_START: begin
          state  <= ST_DATA;
          bitCnt <= '0;
        end
        ST_DATA: begin
          if (lastData) begin
            state   <= parEnQ ? ST_PARITY : ST_STOP;
            stopIdx <= 1'b0;
          end else begin
            bitCnt <= bitCnt + LEN_W'(1);
          end
        end
        ST_PARITY: begin
          state   <= ST_STOP;
          stopIdx <= 1'b0;
        end
        ST_STOP: begin
          if (lastStop) state <= ST_IDLE;
          else          stopIdx <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R2
  start_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (state == ST_START));

  // R3
  data_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitCnt < lenQ));

  // R7
  cfg_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !accept) |=> $stable(lenQ) && $stable(parEnQ) && $stable(twoStopQ));

endmodule

// File: rtl/sftx_datapath.sv
module sftx_datapath
  import sftx_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int MIN_DATA = 5,
  parameter int LEN_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [LEN_W-1:0]  cfgDataLen,
  input  logic [1:0]        cfgParity,
  output logic              txLine
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] keepMask;
  logic              parBitQ;
  logic              onesOdd;
  logic              parNext;
  int                effLen;

  always_comb begin
    effLen = clampLen(int'(cfgDataLen), MIN_DATA, DATA_W);
    for (int i = 0; i < DATA_W; i++) keepMask[i] = (i < effLen);
    onesOdd = ^(inData & keepMask);
    parNext = (cfgParity == PAR_ODD) ? ~onesOdd : onesOdd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBitQ  <= 1'b0;
      txLine   <= 1'b1;
    end else if (strobe.load) begin
      shiftReg <= inData;
      parBitQ  <= parNext;
      txLine   <= 1'b0;
    end else if (strobe.sendData) begin
      txLine   <= shiftReg[0];
      shiftReg <= shiftReg >> 1;
    end else if (strobe.sendParity) begin
      txLine   <= parBitQ;
    end else if (strobe.sendHigh) begin
      txLine   <= 1'b1;
    end
  end

  // R2
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !txLine);

  // R5
  stop_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendHigh |=> txLine);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int MIN_DATA = 5,
  parameter int MAX_DATA = 9,
  parameter int LEN_W    = $clog2(MAX_DATA + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                baudTick,
  input  logic [MAX_DATA-1:0] inData,
  input  logic                inValid,
  output logic                inReady,
  input  logic [LEN_W-1:0]    cfgDataLen,
  input  logic [1:0]          cfgParity,
  input  logic                cfgTwoStop,
  output logic                txLine,
  output logic                busy
);

  txStrobe_t strobe;

  sftx_ctrl #(
    .MIN_DATA(MIN_DATA),
    .MAX_DATA(MAX_DATA),
    .LEN_W   (LEN_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .baudTick  (baudTick),
    .inValid   (inValid),
    .cfgDataLen(cfgDataLen),
    .cfgParity (cfgParity),
    .cfgTwoStop(cfgTwoStop),
    .inReady   (inReady),
    .busy      (busy),
    .strobe    (strobe)
  );

  sftx_datapath #(
    .DATA_W  (MAX_DATA),
    .MIN_DATA(MIN_DATA),
    .LEN_W   (LEN_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .cfgDataLen(cfgDataLen),
    .cfgParity (cfgParity),
    .txLine    (txLine)
  );

  // R8
  line_paced_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(baudTick) |-> $stable(txLine));

  // R2
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> baudTick);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

endmodule

// File: tb/tb_serial_frame_tx.sv
`timescale 1ns/1ps
module tb_serial_frame_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick;
  logic [8:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [3:0] cfgDataLen = 4'd8;
  logic [1:0] cfgParity = 2'd0;
  logic       cfgTwoStop = 1'b0;
  logic       txLine;
  logic       busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit    expQ[$];
  string tagQ[$];

  serial_frame_tx dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .inData(inData),
    .inValid(inValid), .inReady(inReady), .cfgDataLen(cfgDataLen),
    .cfgParity(cfgParity), .cfgTwoStop(cfgTwoStop), .txLine(txLine), .busy(busy)
  );

  always #10 clk = ~clk;

  // tick every fourth clock
  logic [1:0] tickCnt;
  always @(posedge clk) begin
    if (!rstN) begin
      tickCnt  <= '0;
      baudTick <= 1'b0;
    end else begin
      tickCnt  <= tickCnt + 2'd1;
      baudTick <= (tickCnt == 2'd3);
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // monitor: one bit per tick edge, sampled at the following falling edge
  bit   tickSeen = 0;
  logic lastLine = 1'b1;
  bit   monOn = 0;
  always @(posedge clk) tickSeen = baudTick;

  always @(negedge clk) begin
    if (rstN && monOn) begin
      if (tickSeen) begin
        if (expQ.size() > 0) begin
          bit    e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, txLine, e, "line bit");
          check("R9", busy, 1'b1, "busy during frame");
        end else begin
          check("R1", txLine, 1'b1, "idle line");
          check("R9", busy, 1'b0, "busy when idle");
        end
      end else begin
        check("R8", txLine, lastLine, "line stable between ticks");
      end
      lastLine = txLine;
    end
  end

  task automatic sendFrame(input logic [8:0] d, input int len, input int par,
                           input bit two, input string frameTag);
    int eff;
    bit p;
    eff = (len < 5) ? 5 : (len > 9) ? 9 : len;
    @(negedge clk); #1;
    inData     = d;
    cfgDataLen = 4'(len);
    cfgParity  = 2'(par);
    cfgTwoStop = two;
    inValid    = 1'b1;
    p = 1'b0;
    expQ.push_back(1'b0); tagQ.push_back((frameTag == "") ? "R2" : frameTag);
    for (int i = 0; i < eff; i++) begin
      expQ.push_back(d[i]); tagQ.push_back((frameTag == "") ? "R3" : frameTag);
      p = p ^ d[i];
    end
    if (par == 1) begin expQ.push_back(p);  tagQ.push_back("R4"); end
    if (par == 2) begin expQ.push_back(~p); tagQ.push_back("R4"); end
    expQ.push_back(1'b1); tagQ.push_back("R5");
    if (two) begin expQ.push_back(1'b1); tagQ.push_back("R5"); end
    forever begin
      if (inReady) begin
        @(negedge clk); #1;
        break;
      end
      @(negedge clk); #1;
    end
    inValid = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (expQ.size() > 0 || busy);
    repeat (10) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", txLine, 1'b1, "line after reset");
    check("R1", busy, 1'b0, "busy after reset");
    while (baudTick) @(negedge clk);
    check("R2", inReady, 1'b0, "ready without tick");
    monOn = 1;

    sendFrame(9'h0A5, 8, 0, 0, "");
    waitIdle();
    sendFrame(9'h016, 5, 1, 0, "");
    waitIdle();
    sendFrame(9'h1A3, 9, 2, 1, "");
    waitIdle();
    sendFrame(9'h02D, 6, 2, 1, "");
    waitIdle();
    // R3 clamping both ways, R4 code 3 means none
    sendFrame(9'h1FF, 3, 0, 0, "R3");
    sendFrame(9'h155, 12, 3, 0, "R3");
    waitIdle();
    // R6 back-to-back, R7 format inputs change while the previous frame runs
    sendFrame(9'h03C, 7, 1, 0, "R6");
    sendFrame(9'h00F, 5, 2, 1, "R7");
    sendFrame(9'h1C0, 9, 1, 1, "R6");
    sendFrame(9'h0B2, 8, 0, 0, "R7");
    waitIdle();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

endmodule